// File: doc/BRIEF.md
# Serial Receive Path with Character Queue and Line Status

This block turns an asynchronous serial line into characters. A clock enable arriving at sixteen times the bit rate paces an oversampling receiver, which finds each start bit, gathers five to eight data bits least significant first, optionally checks a parity bit, and samples the first stop bit. The receiver checks only that first stop bit, whatever the transmitter sends after it. Each finished character goes into a sixteen-deep queue together with its own parity, framing and break flags.

A host reaches the block through a small register window. A read at address 0 takes the oldest character from the queue. A write at address 2 sets the fill threshold and can flush the queue. A read at address 5 returns the receive line status and clears its sticky error bits. Two outputs follow the queue: one shows that characters are waiting, which suits a DMA engine, and one shows that the fill threshold is reached, which suits an interrupt controller.

Top module: `uart_rx_fifo`

## Requirements
- R1: After a falling edge, the start bit is accepted only if the line is still low on the eighth tick. A low pulse shorter than half a bit adds no entry.
- R2: Data bits are sampled every sixteen ticks, least significant bit first. The count is 5, 6, 7 or 8 for `len_sel` 00, 01, 10 or 11. The unused upper bits of the character read as zero.
- R3: When `par_en`=1 one parity bit follows the data. With `par_stick`=0 the parity is even if `par_even`=1 and odd if it is 0. With `par_stick`=1 the bit must be 1 when `par_even`=0 and 0 when `par_even`=1. A mismatch sets the entry's parity flag. With `par_en`=0 no parity bit is expected.
- R4: A first stop bit sampled as 0 sets the entry's framing flag.
- R5: If data, parity and stop bit are all low, the frame is a break. It gives exactly one entry with value 0x00, with the break and framing flags set and the parity flag clear. No further entry starts until the line has gone high.
- R6: The queue holds 16 characters. A read at address 0 returns the oldest character (0x00 when the queue is empty) and removes it, so characters come out in arrival order.
- R7: A character that completes while 16 are held is dropped, the queue is left as it was, and line status bit 1 (overrun) is set.
- R8: Line status read at address 5 has these bits: bit 0 is high while the queue is not empty, and bit 7 is high while any held entry carries an error flag. Bits 5 and 6 read 0.
- R9: Line status bits 2 (parity), 3 (framing) and 4 (break) collect the flags of each entry when it becomes the oldest. A read at address 5 clears bits 1 to 4. In the same cycle a new event sets its bit again.
- R10: A write at address 2 sets the threshold from data bits 7:6: 00=1, 01=4, 10=8, 11=14. If data bit 1 is 1, the write also empties the queue.
- R11: `rx_ready` is high whenever the queue is not empty. `rx_trig` is high whenever the queue holds at least the threshold.
- R12: The receiver advances only on cycles where `rx_tick` is high, so it works with ticks spaced several clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_tick | input | 1 | Enable at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Character length select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Parity type / stick value select |
| par_stick | input | 1 | Fixed parity value mode |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (character or line status) |
| rx_ready | output | 1 | Queue not empty |
| rx_trig | output | 1 | Queue at or above threshold |

## Verification
The hardest state to reach is a full queue that then takes one more character. Only then is an overrun raised and the existing entries left as they were. The stimulus sets the threshold to fourteen, sends seventeen back-to-back frames without reading, checks the threshold output as the count passes thirteen and fourteen, and then drains the queue to prove the order held. Break frames need the line held low well past one frame and then released. This shows that one entry appears and the receiver waits for the line to go high.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_tick,
  input  logic       rx_in,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic [2:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rx_ready,
  output logic       rx_trig
);
  localparam int TW = $clog2(OSR);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [TW-1:0] T_MID = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] T_END = TW'(OSR - 1);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t           st;
  logic [TW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    dreg;
  logic          pbit;

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, errcnt;
  logic [1:0]    trg_sel;
  logic [CW-1:0] lvl;
  logic [2:0]    hf;
  logic          oe;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire last_bit   = bidx == (3'd4 + {1'b0, len_sel});
  wire exp_par    = par_stick ? ~par_even : (par_even ? ^dreg : ~^dreg);
  wire frame_done = rx_tick && st == S_STOP && tcnt == T_END;
  wire bi_n       = !rx_in && dreg == 8'd0 && (!par_en || !pbit);
  wire fe_n       = !rx_in;
  wire pe_n       = par_en && !bi_n && (pbit != exp_par);
  wire [2:0] new_flags = {bi_n, fe_n, pe_n};

  wire lsr_rd = rd && addr == 3'd5;
  wire clr    = wr && addr == 3'd2 && wdata[1];
  wire pop    = rd && addr == 3'd0 && cnt != '0;
  wire push   = frame_done && !clr && (cnt != FULL || pop);
  wire ovr    = frame_done && !clr && cnt == FULL && !pop;
  wire [10:0] head = mem[rptr];

  logic       unused_ok;
  assign unused_ok = ^{wdata[5:2], wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; bidx <= '0; dreg <= '0; pbit <= 1'b0;
    end else if (rx_tick) begin
      tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE:  if (!rx_in) begin st <= S_START; tcnt <= '0; end
        S_START: if (tcnt == T_MID) begin
                   tcnt <= '0;
                   if (!rx_in) begin st <= S_DATA; bidx <= '0; dreg <= '0; end
                   else st <= S_IDLE;
                 end
        S_DATA:  if (tcnt == T_END) begin
                   dreg[bidx] <= rx_in;
                   if (last_bit) st <= par_en ? S_PAR : S_STOP;
                   else bidx <= bidx + 1'b1;
                 end
        S_PAR:   if (tcnt == T_END) begin pbit <= rx_in; st <= S_STOP; end
        S_STOP:  if (tcnt == T_END) st <= rx_in ? S_IDLE : S_HOLD;
        default: if (rx_in) st <= S_IDLE;
      endcase
    end
  end

  logic       nh_valid;
  logic [2:0] nh_flags;
  always_comb begin
    nh_valid = 1'b0;
    nh_flags = new_flags;
    if (!clr) begin
      if (pop) begin
        if (cnt >= CW'(2)) begin nh_valid = 1'b1; nh_flags = mem[nxt(rptr)][10:8]; end
        else if (push) nh_valid = 1'b1;
      end else if (push && cnt == '0) nh_valid = 1'b1;
    end
  end

  always_ff @(posedge clk) if (push) mem[wptr] <= {new_flags, dreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0; errcnt <= '0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; cnt <= '0; errcnt <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      cnt    <= cnt + CW'(push) - CW'(pop);
      errcnt <= errcnt + CW'(push && |new_flags) - CW'(pop && |head[10:8]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hf <= '0; oe <= 1'b0; trg_sel <= '0;
    end else begin
      hf <= (lsr_rd ? 3'b000 : hf) | (nh_valid ? nh_flags : 3'b000);
      oe <= (oe && !lsr_rd) || ovr;
      if (wr && addr == 3'd2) trg_sel <= wdata[7:6];
    end
  end

  always_comb begin
    case (trg_sel)
      2'd0:    lvl = CW'(1);
      2'd1:    lvl = CW'(4);
      2'd2:    lvl = CW'(8);
      default: lvl = CW'(14);
    endcase
  end

  assign rx_ready = cnt != '0;
  assign rx_trig  = cnt >= lvl;
  assign rdata = (addr == 3'd0) ? (rx_ready ? head[7:0] : 8'd0) :
                 (addr == 3'd5) ? {errcnt != '0, 2'b00, hf, oe, rx_ready} : 8'd0;

  assert_false_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && st == S_START && tcnt == T_MID && rx_in) |=> st == S_IDLE);
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> (cnt == FULL && oe));
  assert_err_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt <= cnt);
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !frame_done) |=> !oe);
  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !rx_ready));
endmodule

// File: tb/uart_rx_fifo_tb_top.sv
module uart_rx_fifo_tb_top;
  logic clk = 0, rst_n = 0, rx_tick, rx_in = 1;
  logic [1:0] len_sel = 2'b11;
  logic par_en = 0, par_even = 0, par_stick = 0;
  logic [2:0] addr = 3'd5;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = 0, rdata;
  logic rx_ready, rx_trig;

  always #2 clk = ~clk;

  int tdiv = 1, tph = 0;
  always_ff @(posedge clk) tph <= (tph + 1 >= tdiv) ? 0 : tph + 1;
  assign rx_tick = (tph == tdiv - 1);

  uart_rx_fifo dut_i (.clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_in(rx_in),
    .len_sel(len_sel), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
    .rx_ready(rx_ready), .rx_trig(rx_trig));

  int n_chk = 0, n_err = 0;
  bit busy = 1;
  string phase = "R8 R11 reset";
  logic [10:0] q[$];
  logic [2:0] m_hf = 0;
  bit m_oe = 0;
  int m_lvl = 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_lsr();
    bit any = 0;
    foreach (q[i]) if (q[i][10:8] != 0) any = 1;
    return {any, 2'b00, m_hf, m_oe, q.size() != 0};
  endfunction

  function automatic void m_push(input logic [7:0] d, input logic [2:0] f);
    if (q.size() == 16) m_oe = 1;
    else begin
      if (q.size() == 0) m_hf |= f;
      q.push_back({f, d});
    end
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && !busy && !rd && !wr) begin
      check(rdata == m_lsr(), {phase, " lsr"}, rdata, m_lsr());
      check(rx_ready == (q.size() != 0), {phase, " rx_ready"}, rx_ready, q.size() != 0);
      check(rx_trig == (q.size() >= m_lvl), {phase, " rx_trig"}, rx_trig, q.size() >= m_lvl);
    end
  end

  task automatic hold(input bit b, input int bits);
    rx_in = b;
    repeat (bits * 16 * tdiv) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int n = 5 + len_sel;
    logic [7:0] dm = d & (8'hFF >> (8 - n));
    logic p = par_stick ? ~par_even : (par_even ? ^dm : ~^dm);
    busy = 1;
    hold(0, 1);
    for (int i = 0; i < n; i++) hold(dm[i], 1);
    if (par_en) hold(p ^ bad_par, 1);
    hold(!bad_stop, 1);
    if (bad_stop) hold(1, 1);
    m_push(dm, {1'b0, bad_stop, par_en && bad_par});
    busy = 0;
  endtask

  task automatic pop_chk(input string req);
    logic [7:0] e = q.size() ? q[0][7:0] : 8'd0;
    rd = 1; addr = 0;
    #1 check(rdata == e, req, rdata, e);
    @(posedge clk);
    if (q.size()) begin
      void'(q.pop_front());
      if (q.size()) m_hf |= q[0][10:8];
    end
    @(negedge clk); rd = 0; addr = 5;
  endtask

  task automatic lsr_chk(input string req);
    logic [7:0] e = m_lsr();
    rd = 1; addr = 5;
    #1 check(rdata == e, req, rdata, e);
    @(posedge clk);
    m_hf = 0; m_oe = 0;
    @(negedge clk); rd = 0;
  endtask

  task automatic fcr(input logic [7:0] v);
    wr = 1; addr = 2; wdata = v;
    @(posedge clk);
    if (v[1]) q.delete();
    m_lvl = (v[7:6] == 0) ? 1 : (v[7:6] == 1) ? 4 : (v[7:6] == 2) ? 8 : 14;
    @(negedge clk); wr = 0; addr = 5;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rdata == 8'h00 && !rx_ready && !rx_trig, "R8 R11 reset state", rdata, 0);
    busy = 0;

    phase = "R2 R6 8-bit";
    send(8'hA5, 0, 0); send(8'h3C, 0, 0);
    check(rx_trig == 1, "R11 trig at level 1", rx_trig, 1);
    pop_chk("R6 first out"); pop_chk("R2 second char");
    pop_chk("R6 empty read");

    phase = "R2 short lengths";
    len_sel = 2'b00; send(8'hF5, 0, 0); pop_chk("R2 5-bit masked");
    len_sel = 2'b10; send(8'hC3, 0, 0); pop_chk("R2 7-bit masked");
    len_sel = 2'b01; send(8'h2A, 0, 0); pop_chk("R2 6-bit");
    len_sel = 2'b11;

    phase = "R3 parity";
    par_en = 1; par_even = 1; send(8'h07, 0, 0); pop_chk("R3 even ok");
    par_even = 0; send(8'h07, 0, 0); pop_chk("R3 odd ok");
    send(8'h55, 1, 0); lsr_chk("R3 R9 parity flag");
    lsr_chk("R9 cleared after read");
    pop_chk("R3 bad parity char");
    par_stick = 1; par_even = 0; send(8'h12, 0, 0); send(8'h13, 1, 0);
    pop_chk("R3 stick one"); lsr_chk("R3 stick one mismatch"); pop_chk("R3 stick");
    par_even = 1; send(8'h66, 0, 0); pop_chk("R3 stick zero");
    par_en = 0; par_stick = 0; par_even = 0;

    phase = "R4 framing";
    send(8'h81, 0, 1); lsr_chk("R4 framing flag"); pop_chk("R4 char kept");

    phase = "R5 break";
    busy = 1; hold(0, 14); hold(1, 2);
    m_push(8'h00, 3'b110); busy = 0;
    lsr_chk("R5 break flags"); pop_chk("R5 break value");
    check(rx_ready == 0, "R5 single entry", rx_ready, 0);

    phase = "R1 glitch";
    busy = 1; rx_in = 0; repeat (4) @(negedge clk); rx_in = 1;
    repeat (40) @(negedge clk); busy = 0;
    check(rx_ready == 0, "R1 glitch ignored", rx_ready, 0);

    phase = "R10 R11 levels";
    fcr(8'h40);
    for (int i = 0; i < 4; i++) send(8'h10 + i, 0, 0);
    check(rx_trig == 1, "R10 level 4 reached", rx_trig, 1);
    fcr(8'h80);
    check(rx_trig == 0, "R10 level 8 not reached", rx_trig, 0);
    fcr(8'h82);
    check(rx_ready == 0, "R10 flush", rx_ready, 0);

    phase = "R7 overrun";
    fcr(8'hC0);
    for (int i = 0; i < 17; i++) begin
      send(8'h40 + i, 0, 0);
      if (i == 12) check(rx_trig == 0, "R11 13 below 14", rx_trig, 0);
      if (i == 13) check(rx_trig == 1, "R11 14 reached", rx_trig, 1);
    end
    lsr_chk("R7 overrun bit");
    for (int i = 0; i < 16; i++) pop_chk("R6 R7 order after overrun");
    check(rx_ready == 0, "R7 drained", rx_ready, 0);
    fcr(8'h00);

    phase = "R12 sparse ticks";
    tdiv = 3;
    send(8'h9E, 0, 0); send(8'h01, 0, 0);
    pop_chk("R12 sparse 1"); pop_chk("R12 sparse 2");
    tdiv = 1;

    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule